// File: doc/BRIEF.md
# Event-Merging Sixteen-Port Aggregator

This block takes fragments from sixteen parallel front-end inputs and turns them into one stream of event records. Each input fragment carries an event number, a per-port sequence number, a data word and a CRC-8. The block collects one fragment per enabled port for the event it is currently building. It checks the CRC and the sequence continuity of each fragment. It then emits a record made of a header beat followed by the accepted fragments, in ascending port order, on a valid/ready/last output stream.

Flow control is push-based. Inputs are granted one at a time, and only while a record is being assembled. While a record is leaving the block, every input is held off. If the output stalls, the current beat is held. For each port, a small counter store keeps two diagnostic counts, sequence gaps and CRC failures. These counts saturate and can be read through an index/selector port.

Top module: `evt_merge_agg`

## Requirements
- R1: There are sixteen inputs, each with a valid/ready handshake. A fragment is taken only when its event field equals the current event number. That number is 0 after reset and advances by one after every record. At most one input is granted per cycle, and the lowest eligible index wins.
- R2: The output word is 26 bits. A record starts with a header beat: bit 25 = 1, bit 24 = sequence-error flag, bits 23:16 = event number, bits 15:0 = mask of contributing ports. One beat then follows per set mask bit, in ascending port order: bit 25 = 0, bits 24:20 = 0, bits 19:16 = port index, bits 15:0 = fragment data. The last beat carries tlast. When the mask is empty, the header itself carries tlast.
- R3: Each fragment's CRC is CRC-8, polynomial 0x07, initial value 0, taken MSB first over the 32-bit word {event, sequence, data}. A fragment whose CRC does not match is consumed but left out of the mask. It increments that port's CRC-error counter and leaves the port's sequence history unchanged.
- R4: Each port expects the sequence number of its previous good fragment plus one, modulo 256. The first expected value after reset is 0. On a mismatch, the port's sequence-gap counter increments, the fragment is still forwarded, and header bit 24 is set.
- R5: A record closes as soon as every enabled port has delivered a fragment, good or bad. Otherwise it closes once the collection timer reaches timeout_i, with the missing ports' mask bits clear. A record with no contributor is still emitted, as a header-only record.
- R6: A port whose enable bit is low is never granted and never appears in a record. With an all-zero enable mask, nothing is accepted, no record is produced and the timer does not run.
- R7: While a record is on the output, every in_ready_o is low. While m_tvalid_o is high and m_tready_i is low, the beat and its tlast are held unchanged.
- R8: A counter is read by setting cnt_port_i and cnt_sel_i (0 = sequence gap, 1 = CRC error). cnt_o shows its value one clock later. Counters saturate at all-ones.
- R9: After reset, m_tvalid_o is low and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 16 | Per-port enable |
| timeout_i | input | TMO_W (12) | Collection timeout in cycles |
| in_valid_i | input | 16 | Fragment valid per port |
| in_ready_o | output | 16 | Fragment accepted per port |
| in_evt_i | input | 16*8 | Event number per port |
| in_seq_i | input | 16*8 | Sequence number per port |
| in_data_i | input | 16*16 | Fragment data per port |
| in_crc_i | input | 16*8 | Fragment CRC-8 per port |
| m_tvalid_o | output | 1 | Output beat valid |
| m_tready_i | input | 1 | Output sink ready |
| m_tdata_o | output | 26 | Output beat |
| m_tlast_o | output | 1 | Last beat of record |
| cnt_port_i | input | 4 | Counter read port index |
| cnt_sel_i | input | 1 | Counter select: 0 gap, 1 CRC |
| cnt_o | output | CNT_W (16) | Counter read data |

## Verification
A wrong grant or a stale done bit would show up at the ports in the next record. It would produce a header mask that differs from the set of good fragments presented, or a fragment beat in the wrong place in the port order. A corrupted sequence history or CRC decision changes the header error flag or the mask bit of the record being built. It also shifts a counter that the next readback exposes. Timer and enable faults show as records that never close, or as extra header-only records within one timeout period.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef enum logic {ST_COLLECT = 1'b0, ST_EMIT = 1'b1} agg_state_e;
  localparam logic [7:0] CRC8_POLY = 8'h07;
endpackage

// File: rtl/agg_crc8.sv
module agg_crc8 import agg_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] msg_i,
  output logic [7:0]   crc_o
);
  always_comb begin
    logic [7:0] c;
    c = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (c[7] ^ msg_i[i]) c = {c[6:0], 1'b0} ^ CRC8_POLY;
      else                 c = {c[6:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/agg_prio_pick.sv
module agg_prio_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  assign gnt_o = req_i & (~req_i + N'(1));
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) if (req_i[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/agg_diag_ram.sv
module agg_diag_ram #(
  parameter int ENTRIES = 32,
  parameter int CNT_W   = 16,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [AW-1:0]    inc_addr_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [CNT_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
      rd_data_o <= '0;
    end else begin
      if (inc_i && mem_q[inc_addr_i] != '1)
        mem_q[inc_addr_i] <= mem_q[inc_addr_i] + CNT_W'(1);
      rd_data_o <= mem_q[rd_addr_i];
    end
  end

  // R8: saturating counters never wrap back
  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_q[g] >= $past(mem_q[g]));
  end
endmodule

// File: rtl/evt_merge_agg.sv
module evt_merge_agg import agg_pkg::*; #(
  parameter int NPORTS = 16,
  parameter int EVT_W  = 8,
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int TMO_W  = 12,
  localparam int PIW   = $clog2(NPORTS),
  localparam int OUT_W = 2 + EVT_W + NPORTS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NPORTS-1:0]        port_en_i,
  input  logic [TMO_W-1:0]         timeout_i,
  input  logic [NPORTS-1:0]        in_valid_i,
  output logic [NPORTS-1:0]        in_ready_o,
  input  logic [NPORTS*EVT_W-1:0]  in_evt_i,
  input  logic [NPORTS*SEQ_W-1:0]  in_seq_i,
  input  logic [NPORTS*DATA_W-1:0] in_data_i,
  input  logic [NPORTS*8-1:0]      in_crc_i,
  output logic                     m_tvalid_o,
  input  logic                     m_tready_i,
  output logic [OUT_W-1:0]         m_tdata_o,
  output logic                     m_tlast_o,
  input  logic [PIW-1:0]           cnt_port_i,
  input  logic                     cnt_sel_i,
  output logic [CNT_W-1:0]         cnt_o
);
  localparam int CRC_IN_W = EVT_W + SEQ_W + DATA_W;

  agg_state_e        state_q;
  logic              hdr_q, err_q;
  logic [EVT_W-1:0]  evt_q;
  logic [NPORTS-1:0] done_q, mask_q, rem_q;
  logic [TMO_W-1:0]  tmr_q;
  logic [SEQ_W-1:0]  last_seq_q [NPORTS];
  logic [DATA_W-1:0] frag_q [NPORTS];

  logic [7:0]        crc_calc [NPORTS];
  logic [NPORTS-1:0] crc_ok, elig, gnt, emit_gnt;
  logic [PIW-1:0]    gnt_idx, emit_idx;
  logic              gnt_any, emit_any;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    agg_crc8 #(.W(CRC_IN_W)) u_crc (
      .msg_i({in_evt_i[p*EVT_W +: EVT_W], in_seq_i[p*SEQ_W +: SEQ_W],
              in_data_i[p*DATA_W +: DATA_W]}),
      .crc_o(crc_calc[p])
    );
    assign crc_ok[p] = crc_calc[p] == in_crc_i[p*8 +: 8];
    assign elig[p]   = port_en_i[p] & ~done_q[p] & in_valid_i[p] &
                       (in_evt_i[p*EVT_W +: EVT_W] == evt_q);
  end

  agg_prio_pick #(.N(NPORTS)) u_pick_in (
    .req_i(elig), .gnt_o(gnt), .idx_o(gnt_idx), .any_o(gnt_any));
  agg_prio_pick #(.N(NPORTS)) u_pick_out (
    .req_i(rem_q), .gnt_o(emit_gnt), .idx_o(emit_idx), .any_o(emit_any));

  logic              take, g_crc_ok, seq_gap, any_en, all_done, close, hs;
  logic [SEQ_W-1:0]  g_seq;
  logic [DATA_W-1:0] g_data;

  assign take     = (state_q == ST_COLLECT) && gnt_any;
  assign g_seq    = in_seq_i[gnt_idx*SEQ_W +: SEQ_W];
  assign g_data   = in_data_i[gnt_idx*DATA_W +: DATA_W];
  assign g_crc_ok = crc_ok[gnt_idx];
  assign seq_gap  = g_seq != last_seq_q[gnt_idx] + SEQ_W'(1);
  assign any_en   = |port_en_i;
  assign all_done = &(done_q | ~port_en_i);
  assign close    = (state_q == ST_COLLECT) && any_en &&
                    (all_done || tmr_q == timeout_i);
  assign in_ready_o = (state_q == ST_COLLECT) ? gnt : '0;

  // gap and CRC counters share one write port; one grant per cycle keeps it single
  agg_diag_ram #(.ENTRIES(2 * NPORTS), .CNT_W(CNT_W)) u_diag (
    .clk_i, .rst_ni,
    .inc_i     (take && (!g_crc_ok || seq_gap)),
    .inc_addr_i({gnt_idx, !g_crc_ok}),
    .rd_addr_i ({cnt_port_i, cnt_sel_i}),
    .rd_data_o (cnt_o)
  );

  always_comb begin
    m_tvalid_o = (state_q == ST_EMIT) && (hdr_q || emit_any);
    m_tdata_o  = '0;
    if (hdr_q) begin
      m_tdata_o[OUT_W-1]          = 1'b1;
      m_tdata_o[OUT_W-2]          = err_q;
      m_tdata_o[NPORTS +: EVT_W]  = evt_q;
      m_tdata_o[NPORTS-1:0]       = mask_q;
      m_tlast_o                   = (mask_q == '0);
    end else begin
      m_tdata_o[DATA_W +: PIW]    = emit_idx;
      m_tdata_o[DATA_W-1:0]       = frag_q[emit_idx];
      m_tlast_o                   = ((rem_q & ~emit_gnt) == '0);
    end
  end
  assign hs = m_tvalid_o && m_tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      hdr_q   <= 1'b1;
      err_q   <= 1'b0;
      evt_q   <= '0;
      done_q  <= '0;
      mask_q  <= '0;
      rem_q   <= '0;
      tmr_q   <= '0;
      for (int i = 0; i < NPORTS; i++) begin
        last_seq_q[i] <= '1;
        frag_q[i]     <= '0;
      end
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (any_en && tmr_q != timeout_i) tmr_q <= tmr_q + TMO_W'(1);
          if (take) begin
            done_q[gnt_idx] <= 1'b1;
            if (g_crc_ok) begin
              mask_q[gnt_idx]     <= 1'b1;
              frag_q[gnt_idx]     <= g_data;
              last_seq_q[gnt_idx] <= g_seq;
              if (seq_gap) err_q <= 1'b1;
            end
          end
          if (close) begin
            state_q <= ST_EMIT;
            hdr_q   <= 1'b1;
          end
        end
        default: begin
          if (hs) begin
            if (hdr_q) begin
              hdr_q <= 1'b0;
              rem_q <= mask_q;
            end else begin
              rem_q <= rem_q & ~emit_gnt;
            end
            if (m_tlast_o) begin
              state_q <= ST_COLLECT;
              hdr_q   <= 1'b1;
              evt_q   <= evt_q + EVT_W'(1);
              done_q  <= '0;
              mask_q  <= '0;
              rem_q   <= '0;
              err_q   <= 1'b0;
              tmr_q   <= '0;
            end
          end
        end
      endcase
    end
  end

  a_r1_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ready_o));
  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o & ~port_en_i) == '0);
  a_r7_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> in_ready_o == '0);
  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o));
endmodule

// File: tb/tb_evt_merge_agg.sv
module tb_evt_merge_agg;
  localparam int NP = 16, EW = 8, SW = 8, DW = 16, CW = 4, TW = 8;
  localparam int OW = 2 + EW + NP;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     en, vld, rdy;
  logic [TW-1:0]     tmo;
  logic [NP*EW-1:0]  evt_bus;
  logic [NP*SW-1:0]  seq_bus;
  logic [NP*DW-1:0]  data_bus;
  logic [NP*8-1:0]   crc_bus;
  logic              tvalid, tready, tlast;
  logic [OW-1:0]     tdata;
  logic [3:0]        cport;
  logic              csel;
  logic [CW-1:0]     cval;

  evt_merge_agg #(.NPORTS(NP), .EVT_W(EW), .SEQ_W(SW), .DATA_W(DW),
                  .CNT_W(CW), .TMO_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(en), .timeout_i(tmo),
    .in_valid_i(vld), .in_ready_o(rdy), .in_evt_i(evt_bus), .in_seq_i(seq_bus),
    .in_data_i(data_bus), .in_crc_i(crc_bus), .m_tvalid_o(tvalid),
    .m_tready_i(tready), .m_tdata_o(tdata), .m_tlast_o(tlast),
    .cnt_port_i(cport), .cnt_sel_i(csel), .cnt_o(cval));

  int n_cmp = 0, n_bad = 0;
  logic [SW-1:0] exp_seq [NP];
  logic [DW-1:0] dsent [NP];
  int gap_cnt [NP], crc_cnt [NP];
  logic [EW-1:0] cur_evt;
  logic [OW-1:0] rec [0:31];
  int  rec_len;
  bit  rec_done, stall_mode;
  logic [NP-1:0] seen_rdy;
  int  multi_rdy = 0, emit_rdy = 0, hold_viol = 0, out_seen = 0;

  function automatic logic [7:0] crc8(input logic [31:0] m);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ m[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // source: drop valid after an accepted handshake
  initial begin
    forever begin
      logic [NP-1:0] acc;
      @(negedge clk);
      acc = vld & rdy;
      seen_rdy = seen_rdy | rdy;
      if ($countones(rdy) > 1) multi_rdy++;
      @(posedge clk);
      #1 vld = vld & ~acc;
    end
  end

  // sink: set ready, then capture beats that will transfer at the next edge
  initial begin
    int cyc = 0;
    bit prev_stall = 0;
    logic [OW-1:0] prev_d = '0;
    forever begin
      @(negedge clk);
      cyc++;
      tready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (prev_stall && (!tvalid || tdata !== prev_d)) hold_viol++;
      prev_stall = tvalid && !tready;
      prev_d = tdata;
      if (tvalid) out_seen++;
      if (tvalid && rdy != '0) emit_rdy++;
      if (tvalid && tready && !rec_done) begin
        rec[rec_len] = tdata;
        rec_len++;
        if (tlast) rec_done = 1;
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  task automatic present_frags(input logic [NP-1:0] present, input logic [NP-1:0] bad,
                               input logic [NP-1:0] gap);
    for (int p = 0; p < NP; p++) begin
      if (present[p]) begin
        logic [SW-1:0] s;
        logic [DW-1:0] d;
        logic [7:0] c;
        s = gap[p] ? exp_seq[p] + SW'(3) : exp_seq[p];
        d = DW'(int'(cur_evt) * 37 + p * 101 + 5);
        c = crc8({cur_evt, s, d});
        if (bad[p]) c = c ^ 8'h5a;
        evt_bus[p*EW +: EW] = cur_evt;
        seq_bus[p*SW +: SW] = s;
        data_bus[p*DW +: DW] = d;
        crc_bus[p*8 +: 8] = c;
        dsent[p] = d;
        vld[p] = 1'b1;
      end
    end
  endtask

  task automatic update_model(input logic [NP-1:0] present, input logic [NP-1:0] bad,
                              input logic [NP-1:0] gap);
    for (int p = 0; p < NP; p++) begin
      if (present[p] && en[p]) begin
        if (bad[p]) begin
          if (crc_cnt[p] < CMAX) crc_cnt[p]++;
        end else begin
          if (gap[p] && gap_cnt[p] < CMAX) gap_cnt[p]++;
          exp_seq[p] = (gap[p] ? exp_seq[p] + SW'(3) : exp_seq[p]) + SW'(1);
        end
      end
    end
  endtask

  task automatic do_event(input logic [NP-1:0] present, input logic [NP-1:0] bad,
                          input logic [NP-1:0] gap, input bit zero_en_first,
                          input string req);
    logic [NP-1:0] m;
    logic [OW-1:0] eh;
    int k, waitc;
    rec_len = 0;
    rec_done = 0;
    seen_rdy = '0;
    @(posedge clk);
    #1;
    if (zero_en_first) en = '0;
    present_frags(present, bad, gap);
    if (zero_en_first) begin
      int seen0 = out_seen;
      repeat (60) @(posedge clk);
      #1;
      chk("R6", "ready with zero enable", seen_rdy, 0);
      chk("R6", "record with zero enable", out_seen - seen0, 0);
      en = '1;
    end
    update_model(present, bad, gap);
    m = present & ~bad & en;
    waitc = 0;
    while (!rec_done && waitc < 3000) begin
      @(posedge clk);
      waitc++;
    end
    chk(req, "record completed", rec_done, 1);
    chk(req, "record length", rec_len, 1 + $countones(m));
    eh = '0;
    eh[OW-1] = 1'b1;
    eh[OW-2] = |(m & gap);
    eh[NP +: EW] = cur_evt;
    eh[NP-1:0] = m;
    chk(req, "header", rec[0], eh);
    k = 1;
    for (int p = 0; p < NP; p++) begin
      if (m[p]) begin
        logic [OW-1:0] eb = '0;
        eb[DW +: 4] = 4'(p);
        eb[DW-1:0] = dsent[p];
        chk(req, "fragment beat", rec[k], eb);
        k++;
      end
    end
    chk("R6", "disabled port granted", seen_rdy & ~en, 0);
    @(posedge clk);
    #1 vld = '0;
    cur_evt = cur_evt + EW'(1);
  endtask

  task automatic rd_cnt(input int p, input bit sel, input int exp, input string req);
    @(negedge clk);
    cport = 4'(p);
    csel = sel;
    @(negedge clk);
    chk(req, sel ? "crc counter" : "gap counter", cval, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    en = '1;
    tmo = TW'(30);
    vld = '0;
    evt_bus = '0; seq_bus = '0; data_bus = '0; crc_bus = '0;
    cport = '0; csel = 1'b0;
    tready = 1'b1;
    stall_mode = 0;
    cur_evt = '0;
    seen_rdy = '0;
    rec_len = 0; rec_done = 1;
    for (int p = 0; p < NP; p++) begin
      exp_seq[p] = '0; gap_cnt[p] = 0; crc_cnt[p] = 0; dsent[p] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "tvalid after reset", tvalid, 0);
    rd_cnt(0, 0, 0, "R9");
    rd_cnt(15, 1, 0, "R9");

    // R1 R2: all ports, clean
    do_event('1, '0, '0, 0, "R1 R2");

    // R3 R4: walking CRC error and sequence gap, with and without stalls (R7)
    for (int p = 0; p < NP; p++) begin
      stall_mode = p[0];
      do_event('1, NP'(1) << ((p + 5) % NP), NP'(1) << p, 0, "R3 R4 R7");
    end
    stall_mode = 0;

    // R5: one missing port each time, then no port at all
    for (int p = 0; p < NP; p++)
      do_event(~(NP'(1) << p), '0, '0, 0, "R5");
    do_event('0, '0, '0, 0, "R5 empty");

    // R6: disabled port presents but is ignored; then all-zero enable
    en = ~NP'(16'h0004);
    do_event('1, '0, '0, 0, "R6");
    en = '1;
    do_event('1, '0, '0, 1, "R6 zero-enable");

    // R8: saturate port 3 CRC counter
    for (int i = 0; i < CMAX + 2; i++)
      do_event('1, NP'(1) << 3, '0, 0, "R3 R8");
    rd_cnt(3, 1, CMAX, "R8 saturation");

    for (int p = 0; p < NP; p++) begin
      rd_cnt(p, 0, gap_cnt[p], "R8 R4");
      rd_cnt(p, 1, crc_cnt[p], "R8 R3");
    end

    chk("R1", "multiple grants in a cycle", multi_rdy, 0);
    chk("R7", "input ready during emit", emit_rdy, 0);
    chk("R7", "beat changed under stall", hold_viol, 0);
    finish_up();
  end
endmodule